// File: doc/BRIEF.md
# Audio Zero-Data Flag Detector

This block sits after the serial audio deframer and watches the decoded left and right sample words. On every sample strobe, which arrives at the word-clock rate, it checks whether each channel's word is exactly zero. It keeps a separate run length for each channel. Once a channel has delivered a fixed number of consecutive all-zero words (1024 by default), that channel is in the silence condition. A single non-zero word ends the run at once.

Two configuration bits decide how the silence conditions appear on the two flag outputs. The mode bit chooses between one flag per channel and a combined flag on both outputs that needs both channels to be silent. The polarity bit inverts the active level of both outputs. The configuration bits come from a register owned elsewhere. Their all-zero value is the reset default, which gives independent, active-high flags. Typical uses of the flags are to drive an external mute circuit or to act as status bits.

Top module: `zero_flag_detect`

## Requirements
- R1: A channel's silence condition becomes true on the sample strobe that delivers the RUN_LEN-th consecutive all-zero word of that channel, counted since reset or since the channel's last non-zero word. It is visible on the flags in the cycle after that clock edge. After RUN_LEN-1 such words it is still false.
- R2: A strobed word with any bit set counts as non-zero. This includes the lowest bit alone and all negative two's-complement values. It clears that channel's run and its silence condition at that same strobe edge.
- R3: The run length saturates at RUN_LEN. Silence continuing for far more than RUN_LEN strobes keeps the condition true and never wraps the count.
- R4: Sample words presented while the strobe is low are ignored. A non-zero word without a strobe neither clears nor advances a run.
- R5: With the mode bit at 0 (independent), flag_left reflects only the left condition and flag_right reflects only the right condition.
- R6: With the mode bit at 1 (common), both outputs carry the same value, which is active only while both channels are silent. Changing the mode bit does not disturb the run counts.
- R7: With the polarity bit at 0, an active flag is 1. With the polarity bit at 1, every flag output is inverted, so an inactive flag reads 1.
- R8: A synchronous active-high reset clears both runs and both silence conditions. During reset and after it, the flags show the inactive level, and counting starts again from zero.
- R9: An all-zero configuration (mode 0, polarity 0) gives independent, active-high flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle strobe per sample period |
| left_smp | input | SAMPLE_W | Left channel sample, two's complement |
| right_smp | input | SAMPLE_W | Right channel sample, two's complement |
| cfg_common | input | 1 | 0 = independent flags, 1 = combined flag |
| cfg_invert | input | 1 | 0 = active-high flags, 1 = active-low flags |
| flag_left | output | 1 | Left (or combined) silence flag |
| flag_right | output | 1 | Right (or combined) silence flag |

## Verification
Some properties hold cycle by cycle, and the embedded assertions check these on every clock:
- the run count never exceeds its ceiling;
- the silence condition and a full count always agree;
- a strobed non-zero word empties the run on the next edge;
- without a strobe nothing moves;
- the common-mode outputs match and need both channels silent.

Other behaviours only appear through stimulus sequences, and the bench's scenarios show these:
- the exact threshold at RUN_LEN-1 versus RUN_LEN words;
- that non-zero words without a strobe are ignored;
- live mode and polarity changes while runs are in progress;
- a reset that lands in the middle of a detected silence, followed by a full recount.

// File: rtl/zflag_pkg.sv
package zflag_pkg;

   // Flag presentation mode, encoded as the configuration bit value
   typedef enum logic {
      FLAG_INDEP  = 1'b0,
      FLAG_COMMON = 1'b1
   } flag_mode_e;

   // Channel slots inside the packed sample array
   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;
   localparam int NUM_CH   = 2;

   // Width needed to hold a count from 0 up to and including lim
   function automatic int run_cnt_width(input int lim);
      return $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/zflag_run_counter.sv
module zflag_run_counter #(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                stb,
   input  logic [SAMPLE_W-1:0] smp,
   output logic                silent
);
   import zflag_pkg::*;

   localparam int CNT_W = run_cnt_width(RUN_LEN);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(RUN_LEN);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

   logic [CNT_W-1:0] run_q;
   logic             silent_q;
   logic             smp_zero;
   logic             reach;

   assign smp_zero = (smp == '0);
   assign reach    = (run_q == LAST) || (run_q == FULL);

   always_ff @(posedge clk) begin
      if (rst) begin
         run_q    <= '0;
         silent_q <= 1'b0;
      end else if (stb) begin
         if (smp_zero) begin
            if (run_q != FULL) begin
               run_q <= run_q + 1'b1;
            end
            silent_q <= reach;
         end else begin
            run_q    <= '0;
            silent_q <= 1'b0;
         end
      end
   end

   assign silent = silent_q;

   // R3
   run_bound_chk: assert property (@(posedge clk) disable iff (rst)
      run_q <= FULL);

   // R1
   silent_needs_full_chk: assert property (@(posedge clk) disable iff (rst)
      silent_q |-> (run_q == FULL));

   // R1
   full_gives_silent_chk: assert property (@(posedge clk) disable iff (rst)
      (run_q == FULL) |-> silent_q);

   // R2
   nonzero_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (stb && !smp_zero) |=> (run_q == '0) && !silent_q);

   // R4
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !stb |=> $stable(run_q) && $stable(silent_q));

   // R3
   sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (stb && smp_zero && run_q == FULL) |=> (run_q == FULL) && silent_q);

endmodule

// File: rtl/zflag_combine.sv
module zflag_combine #(
   parameter bit FLAG_REG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic silent_l,
   input  logic silent_r,
   input  logic cfg_common,
   input  logic cfg_invert,
   output logic flag_l,
   output logic flag_r
);
   import zflag_pkg::*;

   flag_mode_e mode;
   logic       raw_l;
   logic       raw_r;
   logic       lvl_l;
   logic       lvl_r;

   assign mode = flag_mode_e'(cfg_common);

   always_comb begin
      if (mode == FLAG_COMMON) begin
         raw_l = silent_l & silent_r;
         raw_r = silent_l & silent_r;
      end else begin
         raw_l = silent_l;
         raw_r = silent_r;
      end
      lvl_l = raw_l ^ cfg_invert;
      lvl_r = raw_r ^ cfg_invert;
   end

   generate
      if (FLAG_REG) begin : g_reg_out
         logic fl_q;
         logic fr_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               fl_q <= cfg_invert;
               fr_q <= cfg_invert;
            end else begin
               fl_q <= lvl_l;
               fr_q <= lvl_r;
            end
         end
         assign flag_l = fl_q;
         assign flag_r = fr_q;
      end else begin : g_comb_out
         assign flag_l = lvl_l;
         assign flag_r = lvl_r;

         // R6
         common_match_chk: assert property (@(posedge clk) disable iff (rst)
            cfg_common |-> (flag_l == flag_r));

         // R6
         common_needs_both_chk: assert property (@(posedge clk) disable iff (rst)
            (cfg_common && (flag_l != cfg_invert)) |-> (silent_l && silent_r));

         // R7
         inactive_level_chk: assert property (@(posedge clk) disable iff (rst)
            (!silent_l && !silent_r) |-> (flag_l == cfg_invert) && (flag_r == cfg_invert));

         // R5
         indep_right_chk: assert property (@(posedge clk) disable iff (rst)
            (!cfg_common && silent_r) |-> (flag_r != cfg_invert));
      end
   endgenerate

endmodule

// File: rtl/zero_flag_detect.sv
module zero_flag_detect #(
   parameter int SAMPLE_W = 24,
   parameter int RUN_LEN  = 1024,
   parameter bit FLAG_REG = 1'b0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_stb,
   input  logic [SAMPLE_W-1:0] left_smp,
   input  logic [SAMPLE_W-1:0] right_smp,
   input  logic                cfg_common,
   input  logic                cfg_invert,
   output logic                flag_left,
   output logic                flag_right
);
   import zflag_pkg::*;

   generate
      if (SAMPLE_W < 1) begin : g_bad_width
         $error("SAMPLE_W must be at least 1");
      end
      if (RUN_LEN < 2) begin : g_bad_len
         $error("RUN_LEN must be at least 2");
      end
   endgenerate

   logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_arr;
   logic [NUM_CH-1:0]               silent;

   assign smp_arr[CH_LEFT]  = left_smp;
   assign smp_arr[CH_RIGHT] = right_smp;

   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
         zflag_run_counter #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
         ) i_run (
            .clk    (clk),
            .rst    (rst),
            .stb    (smp_stb),
            .smp    (smp_arr[ch]),
            .silent (silent[ch])
         );
      end
   endgenerate

   zflag_combine #(
      .FLAG_REG (FLAG_REG)
   ) i_comb (
      .clk        (clk),
      .rst        (rst),
      .silent_l   (silent[CH_LEFT]),
      .silent_r   (silent[CH_RIGHT]),
      .cfg_common (cfg_common),
      .cfg_invert (cfg_invert),
      .flag_l     (flag_left),
      .flag_r     (flag_right)
   );

endmodule

// File: tb/test_zero_flag_detect.sv
module test_zero_flag_detect;
   localparam int SW  = 24;
   localparam int RUN = 1024;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          smp_stb = 1'b0;
   logic [SW-1:0] left_smp = '0;
   logic [SW-1:0] right_smp = '0;
   logic          cfg_common = 1'b0;
   logic          cfg_invert = 1'b0;
   logic          flag_left;
   logic          flag_right;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit cmp_en = 1'b0;
   string cur_req = "R8";

   // reference model state
   int m_cnt_l = 0;
   int m_cnt_r = 0;

   always #4 clk = ~clk;

   zero_flag_detect #(.SAMPLE_W(SW), .RUN_LEN(RUN)) i_zero_flag_detect (
      .clk(clk), .rst(rst), .smp_stb(smp_stb),
      .left_smp(left_smp), .right_smp(right_smp),
      .cfg_common(cfg_common), .cfg_invert(cfg_invert),
      .flag_left(flag_left), .flag_right(flag_right)
   );

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_cnt_l = 0;
         m_cnt_r = 0;
      end else if (smp_stb) begin
         m_cnt_l = (left_smp != 0)  ? 0 : ((m_cnt_l < RUN) ? m_cnt_l + 1 : m_cnt_l);
         m_cnt_r = (right_smp != 0) ? 0 : ((m_cnt_r < RUN) ? m_cnt_r + 1 : m_cnt_r);
      end
   end

   function automatic bit exp_l();
      bit dl = (m_cnt_l >= RUN);
      bit dr = (m_cnt_r >= RUN);
      return (cfg_common ? (dl && dr) : dl) ^ cfg_invert;
   endfunction

   function automatic bit exp_r();
      bit dl = (m_cnt_l >= RUN);
      bit dr = (m_cnt_r >= RUN);
      return (cfg_common ? (dl && dr) : dr) ^ cfg_invert;
   endfunction

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_en) begin
         checks++;
         if (flag_left !== exp_l() || flag_right !== exp_r()) begin
            errors++;
            $display("FAIL %s cycle %0d: flags l=%b r=%b expected l=%b r=%b",
                     cur_req, cycles, flag_left, flag_right, exp_l(), exp_r());
         end
      end
   end

   task automatic check(input string req, input bit el, input bit er);
      checks++;
      if (flag_left !== el || flag_right !== er) begin
         errors++;
         $display("FAIL %s: flags l=%b r=%b expected l=%b r=%b",
                  req, flag_left, flag_right, el, er);
      end
   endtask

   // drive one cycle; returns 1 time unit after the edge that sampled it
   task automatic send(input bit s, input logic [SW-1:0] l, input logic [SW-1:0] r);
      smp_stb   = s;
      left_smp  = l;
      right_smp = r;
      @(posedge clk);
      #1;
   endtask

   task automatic run(input int n, input logic [SW-1:0] l, input logic [SW-1:0] r);
      for (int i = 0; i < n; i++) send(1'b1, l, r);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run exceeded cycle limit, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2;
      repeat (3) begin @(posedge clk); #1; end
      // R8: flags inactive during reset (polarity 0 -> 0)
      check("R8", 1'b0, 1'b0);
      cfg_invert = 1'b1; #1;
      check("R8", 1'b1, 1'b1);
      cfg_invert = 1'b0;
      rst = 1'b0;
      cmp_en = 1'b1;

      // R1 / R9 / R5: left silent, right active
      cur_req = "R1";
      run(RUN - 1, '0, 24'h000100);
      check("R1", 1'b0, 1'b0);
      run(1, '0, 24'h000100);
      check("R1", 1'b1, 1'b0);
      check("R9", 1'b1, 1'b0);

      // R3: long silence keeps the flag
      cur_req = "R3";
      run(2000, '0, 24'h000100);
      check("R3", 1'b1, 1'b0);

      // R2: lowest bit alone clears at once
      cur_req = "R2";
      run(1, 24'h000001, 24'h000100);
      check("R2", 1'b0, 1'b0);
      run(RUN - 1, '0, 24'h000100);
      check("R2", 1'b0, 1'b0);
      run(1, '0, 24'h000100);
      check("R2", 1'b1, 1'b0);
      run(1, 24'h800000, 24'h000100);
      check("R2", 1'b0, 1'b0);
      run(RUN, '0, 24'h000100);
      run(1, 24'hFFFFFF, 24'h000100);
      check("R2", 1'b0, 1'b0);

      // R4: non-zero words without a strobe are ignored
      cur_req = "R4";
      for (int i = 0; i < RUN; i++) begin
         send(1'b1, '0, 24'h000100);
         send(1'b0, 24'h00ABCD, 24'h000000);
      end
      check("R4", 1'b1, 1'b0);
      send(1'b0, 24'h123456, 24'h654321);
      check("R4", 1'b1, 1'b0);

      // R5: right channel silent too, then left broken
      cur_req = "R5";
      run(RUN, '0, '0);
      check("R5", 1'b1, 1'b1);
      run(1, 24'h000010, '0);
      check("R5", 1'b0, 1'b1);

      // R6: common mode needs both
      cur_req = "R6";
      cfg_common = 1'b1; #1;
      check("R6", 1'b0, 1'b0);
      run(RUN - 1, '0, '0);
      check("R6", 1'b0, 1'b0);
      run(1, '0, '0);
      check("R6", 1'b1, 1'b1);
      run(1, '0, 24'h7FFFFF);
      check("R6", 1'b0, 1'b0);
      cfg_common = 1'b0; #1;
      check("R6", 1'b1, 1'b0);

      // R7: inverted polarity in both modes
      cur_req = "R7";
      cfg_invert = 1'b1; #1;
      check("R7", 1'b0, 1'b1);
      run(RUN, '0, '0);
      check("R7", 1'b0, 1'b0);
      cfg_common = 1'b1; #1;
      check("R7", 1'b0, 1'b0);
      run(1, 24'h000002, '0);
      check("R7", 1'b1, 1'b1);
      cfg_common = 1'b0;
      cfg_invert = 1'b0;

      // R8: reset in the middle of a detected silence
      cur_req = "R8";
      run(RUN, '0, '0);
      check("R8", 1'b1, 1'b1);
      rst = 1'b1;
      send(1'b1, '0, '0);
      check("R8", 1'b0, 1'b0);
      rst = 1'b0;
      run(RUN - 1, '0, '0);
      check("R8", 1'b0, 1'b0);
      run(1, '0, '0);
      check("R8", 1'b1, 1'b1);

      send(1'b0, '0, '0);
      cmp_en = 1'b0;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule